// File: doc/BRIEF.md
# Raster Timing Generator with Trimmable Line Length

This block produces the raster timing for an 864 by 486 picture driven by a pixel clock of about 30 MHz. It keeps a horizontal position counter and a vertical line counter. From their phases it derives display-enable, active-high horizontal and vertical sync, a one-cycle start-of-frame strobe and a flag that marks the vertical blanking lines. Pixels are produced from the top line down, and from left to right within each line.

The length of horizontal blanking is an input that can change at run time. It is clamped to 126..146 pixel times and is taken up only at a frame boundary. Only the horizontal back porch grows or shrinks with it, so the sync position, the sync width and all vertical timing stay fixed. Moving the setting across its range trims the frame rate by about one percent either way around 60 Hz, which lets a downstream video path track an external source. The block does not generate clocks, serialize data or fetch pixels.

Each axis runs a four-state machine with the states ACTIVE, FRONT, SYNC and BACK. The transitions are ACTIVE to FRONT after the last active position, FRONT to SYNC after the last front-porch position, SYNC to BACK after the last sync position, and BACK to ACTIVE at the end of the line (horizontal) or at the end of the frame (vertical). The vertical machine advances only on the cycle that ends a line.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held, pos_x and pos_y are 0, de and sof are 1, and hsync, vsync and vblank are 0. The first frame after reset uses a blanking length of 136.
- R2: pos_x counts up by one on every clock, from 0 to H_ACTIVE + hb - 1, where hb is the blanking length in force. It then returns to 0, so a line lasts H_ACTIVE + hb cycles (1000 at the default).
- R3: Each line runs H_ACTIVE active pixels, then a 40-pixel front porch, then a 32-pixel high pulse on hsync, then a back porch of hb - 72 pixels. hsync rises at pos_x = H_ACTIVE + 40.
- R4: pos_y holds within a line, rises by one when pos_x wraps to 0, and returns to 0 after line 499 (V_ACTIVE + 14 lines per frame).
- R5: Each frame runs V_ACTIVE active lines, then 3 front-porch lines, then 5 lines with vsync high, then 6 back-porch lines. vsync goes high at pos_x 0 of line V_ACTIVE + 3. vblank is 1 on every line from V_ACTIVE onward and only there.
- R6: de is 1 exactly when pos_x < H_ACTIVE and pos_y < V_ACTIVE.
- R7: sof is 1 for one cycle per frame, at pos_x 0 of line 0.
- R8: A requested blanking length below 126 is used as 126, one above 146 is used as 146, and a value in between is used as given.
- R9: A change of the requested blanking length has no effect on the frame in progress. It takes effect from the first pixel of the next frame.
- R10: The blanking length never changes the number of lines per frame, the vsync start line or width, or the vblank line count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hblank_req | input | HB_W | Requested horizontal blanking length in pixel times |
| pos_x | output | X_W | Horizontal position within the line |
| pos_y | output | Y_W | Line index within the frame |
| de | output | 1 | Display enable, high on active pixels of active lines |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| sof | output | 1 | One-cycle start-of-frame strobe |
| vblank | output | 1 | High on the vertical blanking lines |

## Verification
The bench measures whole lines and whole frames at the ports under the default, a trimmed-down, a stretched and two out-of-range blanking settings. A design that moved the sync instead of the back porch would show hsync starting in the wrong column when the setting changes. A design that latched the setting at once would produce a short or long line in the middle of the frame where the change was made, and a design that did not clamp would give frames of the wrong length for the out-of-range requests. Frame measurements also count vsync and vblank lines and sof pulses, which shows whether the vertical timing drifts with the horizontal setting and whether the line counter wraps in the right place.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    // Phase of one raster axis; both axes run the same four phases in order.
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_t;
endpackage

// File: rtl/rtg_hblank_reg.sv
module rtg_hblank_reg #(
    parameter int HB_W   = 9,
    parameter int HB_MIN = 126,
    parameter int HB_MAX = 146,
    parameter int HB_DEF = 136
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HB_W-1:0] hb_req,
    input  logic            frame_end,
    output logic [HB_W-1:0] hb_cur
);
    logic [HB_W-1:0] hb_clamped;
    logic [HB_W-1:0] hb_q;

    // Limit the request to the supported range.
    always_comb begin
        if (hb_req < HB_W'(HB_MIN))
            hb_clamped = HB_W'(HB_MIN);
        else if (hb_req > HB_W'(HB_MAX))
            hb_clamped = HB_W'(HB_MAX);
        else
            hb_clamped = hb_req;
    end

    // Take the new length only on the last pixel of a frame.
    always_ff @(posedge clk) begin
        if (rst)
            hb_q <= HB_W'(HB_DEF);
        else if (frame_end)
            hb_q <= hb_clamped;
    end

    always_comb hb_cur = hb_q;
endmodule

// File: rtl/rtg_hseq.sv
module rtg_hseq
    import rtg_pkg::*;
#(
    parameter int H_ACTIVE = 864,
    parameter int H_FP     = 40,
    parameter int H_SYNC   = 32,
    parameter int HB_W     = 9,
    parameter int X_W      = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HB_W-1:0] hb_cur,
    output logic [X_W-1:0]  x,
    output phase_t          phase,
    output logic            line_end
);
    localparam int ACT_LAST  = H_ACTIVE - 1;
    localparam int FP_LAST   = ACT_LAST + H_FP;
    localparam int SYNC_LAST = FP_LAST + H_SYNC;

    phase_t         st_q, st_d;
    logic [X_W-1:0] x_q;
    logic [X_W-1:0] last_x;
    logic           at_last;

    assign last_x  = X_W'(ACT_LAST) + X_W'(hb_cur);
    assign at_last = (x_q == last_x);

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_ACTIVE: if (x_q == X_W'(ACT_LAST))  st_d = PH_FRONT;
            PH_FRONT:  if (x_q == X_W'(FP_LAST))   st_d = PH_SYNC;
            PH_SYNC:   if (x_q == X_W'(SYNC_LAST)) st_d = PH_BACK;
            PH_BACK:   if (at_last)                st_d = PH_ACTIVE;
        endcase
    end

    // State and position register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PH_ACTIVE;
            x_q  <= '0;
        end else begin
            st_q <= st_d;
            x_q  <= at_last ? '0 : x_q + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        x        = x_q;
        phase    = st_q;
        line_end = (st_q == PH_BACK) && at_last;
    end
endmodule

// File: rtl/rtg_vseq.sv
module rtg_vseq
    import rtg_pkg::*;
#(
    parameter int V_ACTIVE = 486,
    parameter int V_FP     = 3,
    parameter int V_SYNC   = 5,
    parameter int V_BP     = 6,
    parameter int Y_W      = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           line_end,
    output logic [Y_W-1:0] y,
    output phase_t         phase,
    output logic           frame_end
);
    localparam int ACT_LAST  = V_ACTIVE - 1;
    localparam int FP_LAST   = ACT_LAST + V_FP;
    localparam int SYNC_LAST = FP_LAST + V_SYNC;
    localparam int Y_LAST    = SYNC_LAST + V_BP;

    phase_t         st_q, st_d;
    logic [Y_W-1:0] y_q;
    logic           at_last;

    assign at_last = (y_q == Y_W'(Y_LAST));

    // Next-state logic; the machine moves only on a line boundary.
    always_comb begin
        st_d = st_q;
        if (line_end) begin
            unique case (st_q)
                PH_ACTIVE: if (y_q == Y_W'(ACT_LAST))  st_d = PH_FRONT;
                PH_FRONT:  if (y_q == Y_W'(FP_LAST))   st_d = PH_SYNC;
                PH_SYNC:   if (y_q == Y_W'(SYNC_LAST)) st_d = PH_BACK;
                PH_BACK:   if (at_last)                st_d = PH_ACTIVE;
            endcase
        end
    end

    // State and line register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PH_ACTIVE;
            y_q  <= '0;
        end else begin
            st_q <= st_d;
            if (line_end)
                y_q <= at_last ? '0 : y_q + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        y         = y_q;
        phase     = st_q;
        frame_end = line_end && (st_q == PH_BACK) && at_last;
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int H_ACTIVE = 864,
    parameter int H_FP     = 40,
    parameter int H_SYNC   = 32,
    parameter int V_ACTIVE = 486,
    parameter int V_FP     = 3,
    parameter int V_SYNC   = 5,
    parameter int V_BP     = 6,
    parameter int HB_MIN   = 126,
    parameter int HB_MAX   = 146,
    parameter int HB_DEF   = 136,
    parameter int HB_W     = 9,
    localparam int X_W     = $clog2(H_ACTIVE + HB_MAX),
    localparam int Y_W     = $clog2(V_ACTIVE + V_FP + V_SYNC + V_BP)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [HB_W-1:0] hblank_req,
    output logic [X_W-1:0]  pos_x,
    output logic [Y_W-1:0]  pos_y,
    output logic            de,
    output logic            hsync,
    output logic            vsync,
    output logic            sof,
    output logic            vblank
);
    logic [HB_W-1:0] hb_cur;
    logic            line_end;
    logic            frame_end;
    phase_t          h_phase;
    phase_t          v_phase;
    logic [X_W-1:0]  x_w;
    logic [Y_W-1:0]  y_w;

    rtg_hblank_reg #(
        .HB_W(HB_W), .HB_MIN(HB_MIN), .HB_MAX(HB_MAX), .HB_DEF(HB_DEF)
    ) hb_i (
        .clk(clk), .rst(rst), .hb_req(hblank_req),
        .frame_end(frame_end), .hb_cur(hb_cur)
    );

    rtg_hseq #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC),
        .HB_W(HB_W), .X_W(X_W)
    ) hseq_i (
        .clk(clk), .rst(rst), .hb_cur(hb_cur),
        .x(x_w), .phase(h_phase), .line_end(line_end)
    );

    rtg_vseq #(
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC),
        .V_BP(V_BP), .Y_W(Y_W)
    ) vseq_i (
        .clk(clk), .rst(rst), .line_end(line_end),
        .y(y_w), .phase(v_phase), .frame_end(frame_end)
    );

    always_comb begin
        pos_x  = x_w;
        pos_y  = y_w;
        de     = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        hsync  = (h_phase == PH_SYNC);
        vsync  = (v_phase == PH_SYNC);
        vblank = (v_phase != PH_ACTIVE);
        sof    = (x_w == '0) && (y_w == '0);
    end
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
    parameter int H_ACTIVE = 864,
    parameter int H_FP     = 40,
    parameter int V_ACTIVE = 486,
    parameter int V_FP     = 3,
    parameter int X_W      = 10,
    parameter int Y_W      = 9
) (
    input logic           clk,
    input logic           rst,
    input logic [X_W-1:0] pos_x,
    input logic [Y_W-1:0] pos_y,
    input logic           de,
    input logic           hsync,
    input logic           vsync,
    input logic           sof,
    input logic           vblank
);
    // R2: position steps by one except where it wraps to zero
    a_r2_x_step: assert property (@(posedge clk) disable iff (rst)
        (pos_x != '0) |-> (pos_x == X_W'($past(pos_x) + 1'b1)));

    // R4: line index only moves at the start of a line
    a_r4_y_hold: assert property (@(posedge clk) disable iff (rst)
        (pos_x != '0) |-> $stable(pos_y));

    // R3: sync begins after the active area and the front porch
    a_r3_hs_place: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> (int'(pos_x) == H_ACTIVE + H_FP));

    // R3: sync never overlaps displayed pixels
    a_r3_hs_no_de: assert property (@(posedge clk) disable iff (rst)
        hsync |-> !de);

    // R5: vertical sync starts on the first pixel of its line
    a_r5_vs_place: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> (int'(pos_y) == V_ACTIVE + V_FP && pos_x == '0));

    // R5: vertical sync lies inside vertical blanking
    a_r5_vs_in_blank: assert property (@(posedge clk) disable iff (rst)
        vsync |-> vblank);

    // R6: enable only inside the active rectangle
    a_r6_de_area: assert property (@(posedge clk) disable iff (rst)
        de |-> (int'(pos_x) < H_ACTIVE && int'(pos_y) < V_ACTIVE));

    // R7: frame strobe lasts one cycle
    a_r7_sof_pulse: assert property (@(posedge clk) disable iff (rst)
        sof |=> !sof);
endmodule

bind raster_timing_gen raster_timing_chk #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .V_ACTIVE(V_ACTIVE), .V_FP(V_FP),
    .X_W(X_W), .Y_W(Y_W)
) chk_i (
    .clk(clk), .rst(rst), .pos_x(pos_x), .pos_y(pos_y), .de(de),
    .hsync(hsync), .vsync(vsync), .sof(sof), .vblank(vblank)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
    localparam int HA   = 96;
    localparam int VA   = 12;
    localparam int VT   = VA + 14;
    localparam int X_W  = $clog2(HA + 146);
    localparam int Y_W  = $clog2(VT);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [8:0]     hblank_req = 9'd136;
    logic [X_W-1:0] pos_x;
    logic [Y_W-1:0] pos_y;
    logic           de, hsync, vsync, sof, vblank;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    raster_timing_gen #(.H_ACTIVE(HA), .V_ACTIVE(VA)) dut_i (
        .clk(clk), .rst(rst), .hblank_req(hblank_req),
        .pos_x(pos_x), .pos_y(pos_y), .de(de), .hsync(hsync),
        .vsync(vsync), .sof(sof), .vblank(vblank)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    task automatic wait_line(input int ln);
        @(negedge clk);
        while (!(pos_x == '0 && int'(pos_y) == ln)) @(negedge clk);
    endtask

    // Starts at pixel 0 of line ln and runs to the next pixel 0.
    task automatic measure_line(input int ln, output int len, output int hs_start,
                                output int hs_len, output int de_len, output int seq_err);
        wait_line(ln);
        len = 0; hs_start = -1; hs_len = 0; de_len = 0; seq_err = 0;
        do begin
            if (int'(pos_x) != len) seq_err++;
            if (hsync) begin
                if (hs_len == 0) hs_start = int'(pos_x);
                hs_len++;
            end
            if (de) de_len++;
            len++;
            @(negedge clk);
        end while (pos_x != '0);
    endtask

    // Runs from one frame strobe to the next.
    task automatic measure_frame(output int cyc, output int lines, output int vs_start,
                                 output int vs_lines, output int vb_lines, output int de_lines,
                                 output int sof_cnt, output int seq_err);
        cyc = 0; lines = 0; vs_start = -1; vs_lines = 0; vb_lines = 0;
        de_lines = 0; sof_cnt = 0; seq_err = 0;
        @(negedge clk);
        while (!sof) @(negedge clk);
        do begin
            if (sof) sof_cnt++;
            if (pos_x == '0) begin
                if (int'(pos_y) != lines) seq_err++;
                if (vsync) begin
                    if (vs_lines == 0) vs_start = int'(pos_y);
                    vs_lines++;
                end
                if (vblank) vb_lines++;
                if (de) de_lines++;
                lines++;
            end
            cyc++;
            @(negedge clk);
        end while (!sof);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "pos_x in reset", int'(pos_x), 0);
        chk("R1", "pos_y in reset", int'(pos_y), 0);
        chk("R1", "de in reset", int'(de), 1);
        chk("R1", "sof in reset", int'(sof), 1);
        chk("R1", "hsync in reset", int'(hsync), 0);
        chk("R1", "vsync in reset", int'(vsync), 0);
        chk("R1", "vblank in reset", int'(vblank), 0);
        rst = 1'b0;
    endtask

    task automatic t_line_default();
        int len, hs, hl, dl, se;
        measure_line(2, len, hs, hl, dl, se);
        chk("R2", "line length default", len, HA + 136);
        chk("R2", "x sequence errors", se, 0);
        chk("R3", "hsync start column", hs, HA + 40);
        chk("R3", "hsync width", hl, 32);
        chk("R6", "de pixels on active line", dl, HA);
        measure_line(VA + 1, len, hs, hl, dl, se);
        chk("R6", "de pixels on blank line", dl, 0);
    endtask

    task automatic t_frame_default();
        int cyc, ln, vs, vl, vb, dl, sc, se;
        measure_frame(cyc, ln, vs, vl, vb, dl, sc, se);
        chk("R1", "first frame cycles at default", cyc, VT * (HA + 136));
        chk("R4", "lines per frame", ln, VT);
        chk("R4", "y sequence errors", se, 0);
        chk("R5", "vsync start line", vs, VA + 3);
        chk("R5", "vsync lines", vl, 5);
        chk("R5", "vblank lines", vb, 14);
        chk("R6", "active lines", dl, VA);
        chk("R7", "sof cycles per frame", sc, 1);
    endtask

    task automatic t_midframe_change();
        int len, hs, hl, dl, se;
        int cyc, ln, vs, vl, vb, sc;
        wait_line(3);
        hblank_req = 9'd146;
        measure_line(5, len, hs, hl, dl, se);
        chk("R9", "line length after mid-frame change", len, HA + 136);
        measure_frame(cyc, ln, vs, vl, vb, dl, sc, se);
        chk("R9", "next frame cycles at 146", cyc, VT * (HA + 146));
        chk("R10", "lines per frame at 146", ln, VT);
        chk("R10", "vsync start line at 146", vs, VA + 3);
        chk("R10", "vsync lines at 146", vl, 5);
        chk("R10", "vblank lines at 146", vb, 14);
        measure_line(4, len, hs, hl, dl, se);
        chk("R3", "line length at 146", len, HA + 146);
        chk("R3", "hsync start column at 146", hs, HA + 40);
        chk("R3", "hsync width at 146", hl, 32);
    endtask

    task automatic t_clamp();
        int cyc, ln, vs, vl, vb, dl, sc, se;
        hblank_req = 9'd50;
        measure_frame(cyc, ln, vs, vl, vb, dl, sc, se);
        chk("R8", "frame cycles for request 50", cyc, VT * (HA + 126));
        chk("R10", "vsync start line at 126", vs, VA + 3);
        hblank_req = 9'd300;
        measure_frame(cyc, ln, vs, vl, vb, dl, sc, se);
        chk("R8", "frame cycles for request 300", cyc, VT * (HA + 146));
        hblank_req = 9'd130;
        measure_frame(cyc, ln, vs, vl, vb, dl, sc, se);
        chk("R8", "frame cycles for request 130", cyc, VT * (HA + 130));
        chk("R10", "lines per frame at 130", ln, VT);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        t_reset();
        t_line_default();
        t_frame_default();
        t_midframe_change();
        t_clamp();
        report();
        $finish;
    end
endmodule